// File: doc/BRIEF.md
# Time-Multiplexed Programmable FIR Filter Bank

This block filters slow sensor samples with a direct-form FIR response and no feedback path. Each of its four lanes owns exactly one multiplier and one adder. A lane accumulates one coefficient-times-sample product per fast-clock cycle. The whole filter sum for a new sample is therefore built up over a run of fast cycles that fits inside the slower sample period. The tap count is chosen per sample: a long setting of 30 taps, or a short setting of 15 taps that costs fewer cycles and gives a coarser response.

Samples arrive one lane at a time on a per-lane strobe. Coefficients are written through a small write port that selects the lane and the tap. Each lane raises a one-cycle valid pulse when its result is ready. It also drives a clock-enable output that is high only while products are being accumulated, so downstream clock gating can stop the lane for the rest of the sample period. A lane can be switched off on its own. A strobe that arrives before the previous result is finished is flagged, and the new sample takes over.

Top module: `fir_mux_bank`

## Requirements
- R1: After reset, every lane has y_valid low, clk_en low and overrun low, and all its stored samples and coefficients are zero.
- R2: For each accepted sample, a lane outputs y = sum over k from 0 to L-1 of c[k]*x[k]. Here x[0] is the sample just accepted, x[k] is the sample accepted k strobes earlier on that lane (zero if none), and c[k] is the coefficient at tap k. All values are signed two's complement, and y_out is 21-bit signed per lane.
- R3: L is 30 when half_mode is 0 and 15 when half_mode is 1. The value is taken on the strobe cycle, and a change of half_mode during a computation does not alter that result.
- R4: y_valid is high for exactly one cycle. When the strobe is captured at clock edge E0, y_valid is high in the cycle after edge E0+L. y_out keeps the result until the next result replaces it.
- R5: clk_en of a lane is high in exactly the L cycles following the strobe edge and low in all other cycles.
- R6: A coefficient write (cw_en=1) targets lane cw_lane, tap cw_tap (5-bit, 0 to 29), with cw_data as a signed 8-bit value. It takes effect only if that lane is not computing. Writes to a lane that is computing, and writes with cw_tap of 30 or 31, are ignored.
- R7: A strobe that arrives while the lane is computing sets that lane's overrun flag, which stays high until reset. The unfinished result is dropped with no valid pulse, and the new sample is processed normally.
- R8: While lane_en is low for a lane, its strobes are ignored and its stored samples are unchanged. It gives no valid pulse, its clk_en stays low, and any computation in progress is abandoned.
- R9: Full-scale inputs do not overflow. With 30 coefficients and 30 samples all equal to -128, y is 491520.
- R10: Lanes are independent. Strobes, writes and overruns on one lane do not affect the results, flags or timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 4 | Per-lane enable |
| smp_stb | input | 4 | Per-lane sample strobe |
| smp_in | input | 32 | Per-lane signed 8-bit samples, lane i at bits [8i+7:8i] |
| half_mode | input | 1 | 1 selects 15 taps, 0 selects 30 taps |
| cw_en | input | 1 | Coefficient write request |
| cw_lane | input | 2 | Lane addressed by the write |
| cw_tap | input | 5 | Tap addressed by the write |
| cw_data | input | 8 | Signed coefficient value |
| y_out | output | 84 | Per-lane signed 21-bit results, lane i at bits [21i+20:21i] |
| y_valid | output | 4 | Per-lane one-cycle result pulse |
| clk_en | output | 4 | Per-lane fast-clock activity enable |
| overrun | output | 4 | Per-lane sticky overrun flag |

## Verification
A tap pointer that skips or repeats an index, or a wrongly latched tap count, shows up at the ports within one sample period. The result value is wrong, or y_valid and the falling edge of clk_en land in the wrong cycle. A corrupt stored sample or coefficient is not visible at once. It only shows in a later result, so the bench sends runs of samples and compares every result against a reference model. A control state stuck in computing shows as clk_en staying high, and it turns the next strobe into an overrun.

// File: rtl/fir_mux_pkg.sv
package fir_mux_pkg;
    localparam int SMP_W      = 8;
    localparam int COEF_W     = 8;
    localparam int TAPS_FULL  = 30;
    localparam int TAPS_HALF  = 15;
    localparam int PROD_W     = SMP_W + COEF_W;
    localparam int ACC_W      = PROD_W + $clog2(TAPS_FULL);
    localparam int TAP_IDX_W  = $clog2(TAPS_FULL);

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [TAP_IDX_W-1:0]     tap_t;

    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_BUSY = 2'd1,
        LANE_DONE = 2'd2
    } lane_state_e;

    typedef struct packed {
        logic  en;
        tap_t  tap;
        coef_t data;
    } coef_wr_t;

    function automatic tap_t last_tap(input logic half);
        return half ? tap_t'(TAPS_HALF - 1) : tap_t'(TAPS_FULL - 1);
    endfunction
endpackage

// File: rtl/fir_tap_seq.sv
module fir_tap_seq
    import fir_mux_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lane_en,
    input  logic strobe,
    input  logic half_sel,
    output logic busy,
    output logic start,
    output logic add_en,
    output logic finish,
    output tap_t tap_idx,
    output logic res_valid,
    output logic overrun,
    output logic clk_en
);
    lane_state_e st_q;
    tap_t        tap_q;
    tap_t        lim_q;
    logic        vld_q;
    logic        ovr_q;

    assign busy   = (st_q == LANE_BUSY);
    assign start  = lane_en & strobe;
    assign add_en = busy & lane_en & ~strobe;
    assign finish = add_en & (tap_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LANE_IDLE;
            tap_q <= '0;
            lim_q <= '0;
            vld_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (!lane_en) begin
                st_q  <= LANE_IDLE;
                tap_q <= '0;
            end else if (strobe) begin
                if (busy) ovr_q <= 1'b1;
                st_q  <= LANE_BUSY;
                tap_q <= '0;
                lim_q <= last_tap(half_sel);
            end else if (finish) begin
                st_q  <= LANE_DONE;
                vld_q <= 1'b1;
            end else if (busy) begin
                tap_q <= tap_q + tap_t'(1);
            end
        end
    end

    assign tap_idx   = tap_q;
    assign res_valid = vld_q;
    assign overrun   = ovr_q;
    assign clk_en    = busy;

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);
    assert_valid_in_done_R5: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (st_q == LANE_DONE));
    assert_tap_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tap_q <= lim_q));
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);
    assert_off_lane_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !lane_en |=> (st_q == LANE_IDLE) && !vld_q);
endmodule

// File: rtl/fir_sample_line.sv
module fir_sample_line
    import fir_mux_pkg::*;
#(
    parameter int DEPTH = TAPS_FULL
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  smp_t din,
    input  tap_t rd_idx,
    output smp_t dout
);
    smp_t line_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)        line_q[0] <= '0;
        else if (shift) line_q[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        line_q[g] <= '0;
            else if (shift) line_q[g] <= line_q[g-1];
        end
    end

    assign dout = (int'(rd_idx) < DEPTH) ? line_q[rd_idx] : '0;
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store
    import fir_mux_pkg::*;
#(
    parameter int DEPTH = TAPS_FULL
) (
    input  logic     clk,
    input  logic     rst,
    input  coef_wr_t wr,
    input  logic     lock,
    input  tap_t     rd_idx,
    output coef_t    rd_data
);
    logic [DEPTH-1:0][COEF_W-1:0] mem_q;
    logic                         wr_ok;

    assign wr_ok = wr.en & ~lock & (int'(wr.tap) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst)        mem_q <= '0;
        else if (wr_ok) mem_q[wr.tap] <= wr.data;
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? coef_t'(mem_q[rd_idx]) : '0;

    assert_locked_write_R6: assert property (@(posedge clk) disable iff (rst)
        (lock && wr.en) |=> $stable(mem_q));
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit
    import fir_mux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  add_en,
    input  logic  finish,
    input  smp_t  smp,
    input  coef_t coef,
    output acc_t  result
);
    prod_t              prod;
    acc_t               acc_q;
    acc_t               res_q;
    logic signed [ACC_W:0] sum_w;

    assign prod  = smp * coef;
    assign sum_w = {acc_q[ACC_W-1], acc_q}
                 + {{(ACC_W + 1 - PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (clear)       acc_q <= '0;
            else if (add_en) acc_q <= sum_w[ACC_W-1:0];
            if (finish)      res_q <= sum_w[ACC_W-1:0];
        end
    end

    assign result = res_q;

    assert_acc_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_q == '0));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        add_en |-> (sum_w[ACC_W] == sum_w[ACC_W-1]));
endmodule

// File: rtl/fir_lane.sv
module fir_lane
    import fir_mux_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lane_en,
    input  logic     strobe,
    input  logic     half_sel,
    input  smp_t     smp,
    input  coef_wr_t wr,
    output acc_t     y,
    output logic     y_valid,
    output logic     clk_en,
    output logic     overrun
);
    logic  busy, start, add_en, finish;
    tap_t  tap_idx;
    smp_t  tap_smp;
    coef_t tap_coef;

    fir_tap_seq u_seq (
        .clk(clk), .rst(rst), .lane_en(lane_en), .strobe(strobe),
        .half_sel(half_sel), .busy(busy), .start(start), .add_en(add_en),
        .finish(finish), .tap_idx(tap_idx), .res_valid(y_valid),
        .overrun(overrun), .clk_en(clk_en)
    );

    fir_sample_line #(.DEPTH(TAPS_FULL)) u_line (
        .clk(clk), .rst(rst), .shift(start), .din(smp),
        .rd_idx(tap_idx), .dout(tap_smp)
    );

    fir_coef_store #(.DEPTH(TAPS_FULL)) u_coef (
        .clk(clk), .rst(rst), .wr(wr), .lock(busy),
        .rd_idx(tap_idx), .rd_data(tap_coef)
    );

    fir_mac_unit u_mac (
        .clk(clk), .rst(rst), .clear(start), .add_en(add_en),
        .finish(finish), .smp(tap_smp), .coef(tap_coef), .result(y)
    );
endmodule

// File: rtl/fir_mux_bank.sv
module fir_mux_bank
    import fir_mux_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LANE_SEL_W = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES-1:0]         smp_stb,
    input  logic [LANES*SMP_W-1:0]   smp_in,
    input  logic                     half_mode,
    input  logic                     cw_en,
    input  logic [LANE_SEL_W-1:0]    cw_lane,
    input  logic [TAP_IDX_W-1:0]     cw_tap,
    input  logic [COEF_W-1:0]        cw_data,
    output logic [LANES*ACC_W-1:0]   y_out,
    output logic [LANES-1:0]         y_valid,
    output logic [LANES-1:0]         clk_en,
    output logic [LANES-1:0]         overrun
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        coef_wr_t wr_i;
        acc_t     y_i;

        assign wr_i.en   = cw_en & (cw_lane == LANE_SEL_W'(i));
        assign wr_i.tap  = cw_tap;
        assign wr_i.data = coef_t'(cw_data);

        fir_lane u_lane (
            .clk(clk), .rst(rst), .lane_en(lane_en[i]), .strobe(smp_stb[i]),
            .half_sel(half_mode), .smp(smp_t'(smp_in[i*SMP_W +: SMP_W])),
            .wr(wr_i), .y(y_i), .y_valid(y_valid[i]), .clk_en(clk_en[i]),
            .overrun(overrun[i])
        );

        assign y_out[i*ACC_W +: ACC_W] = y_i;
    end
endmodule

// File: tb/fir_mux_bank_tb_top.sv
module fir_mux_bank_tb_top;
    import fir_mux_pkg::*;

    localparam int NL = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NL-1:0]     lane_en = '1;
    logic [NL-1:0]     smp_stb = '0;
    logic [NL*8-1:0]   smp_in = '0;
    logic              half_mode = 1'b0;
    logic              cw_en = 1'b0;
    logic [1:0]        cw_lane = '0;
    logic [4:0]        cw_tap = '0;
    logic [7:0]        cw_data = '0;
    logic [NL*ACC_W-1:0] y_out;
    logic [NL-1:0]     y_valid, clk_en, overrun;

    always #5 clk = ~clk;

    fir_mux_bank dut_i (
        .clk(clk), .rst(rst), .lane_en(lane_en), .smp_stb(smp_stb),
        .smp_in(smp_in), .half_mode(half_mode), .cw_en(cw_en),
        .cw_lane(cw_lane), .cw_tap(cw_tap), .cw_data(cw_data),
        .y_out(y_out), .y_valid(y_valid), .clk_en(clk_en), .overrun(overrun)
    );

    typedef struct { int ch; int val; } exp_t;
    exp_t exp_q[$];

    int  m_dl [NL][TAPS_FULL];
    int  m_cf [NL][TAPS_FULL];
    int  samp_v [NL];
    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // scoreboard monitor: every valid pulse must match the oldest expectation
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NL; c++) begin
                if (y_valid[c]) begin
                    int act;
                    act = int'($signed(y_out[c*ACC_W +: ACC_W]));
                    if (exp_q.size() == 0) begin
                        chk(0, "R2 R7 R8 unexpected result", c, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(e.ch == c, "R10 result lane", c, e.ch);
                        chk(act == e.val, "R2 R3 R9 result value", act, e.val);
                    end
                end
            end
        end
    end

    task automatic wr_coef(input int ch, input int tap, input int val, input bit accepted);
        @(negedge clk);
        cw_en = 1'b1; cw_lane = 2'(ch); cw_tap = 5'(tap); cw_data = 8'(val);
        if (accepted) m_cf[ch][tap] = val;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    // driver: updates the model, pushes the expected result, pulses strobes
    task automatic send(input logic [NL-1:0] mask, input bit push);
        @(negedge clk);
        for (int c = 0; c < NL; c++) begin
            smp_in[c*8 +: 8] = 8'(samp_v[c]);
            if (mask[c] && lane_en[c]) begin
                for (int k = TAPS_FULL-1; k > 0; k--) m_dl[c][k] = m_dl[c][k-1];
                m_dl[c][0] = samp_v[c];
                if (push) begin
                    exp_t e;
                    int L;
                    L = half_mode ? TAPS_HALF : TAPS_FULL;
                    e.ch = c; e.val = 0;
                    for (int k = 0; k < L; k++) e.val += m_cf[c][k] * m_dl[c][k];
                    exp_q.push_back(e);
                end
            end
        end
        smp_stb = mask;
        @(negedge clk);
        smp_stb = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R4 / R5 timing measurement on one lane
    task automatic timing(input int ch, input bit half);
        int n, en_cnt, L;
        half_mode = half;
        L = half ? TAPS_HALF : TAPS_FULL;
        for (int c = 0; c < NL; c++) samp_v[c] = 3 * ch + 5;
        send(NL'(1) << ch, 1);
        n = 1;
        en_cnt = clk_en[ch] ? 1 : 0;
        while (!y_valid[ch] && n < 100) begin
            @(negedge clk);
            n++;
            if (clk_en[ch]) en_cnt++;
        end
        chk(n == L + 1, "R4 valid latency", n, L + 1);
        chk(en_cnt == L, "R5 clk_en active cycles", en_cnt, L);
        chk(clk_en[ch] == 1'b0, "R5 clk_en low at result", int'(clk_en[ch]), 0);
        @(negedge clk);
        chk(y_valid[ch] == 1'b0, "R4 valid one cycle", int'(y_valid[ch]), 0);
        idle(3);
        chk(clk_en[ch] == 1'b0, "R5 clk_en low after done", int'(clk_en[ch]), 0);
    endtask

    initial begin
        for (int c = 0; c < NL; c++)
            for (int k = 0; k < TAPS_FULL; k++) begin
                m_dl[c][k] = 0; m_cf[c][k] = 0;
            end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(y_valid == '0, "R1 y_valid reset", int'(y_valid), 0);
        chk(clk_en == '0, "R1 clk_en reset", int'(clk_en), 0);
        chk(overrun == '0, "R1 overrun reset", int'(overrun), 0);
        chk(y_out == '0, "R1 y_out reset", 0, 0);

        // R6: load distinct coefficient sets into all lanes while idle
        for (int c = 0; c < NL; c++)
            for (int k = 0; k < TAPS_FULL; k++)
                wr_coef(c, k, ((k * 7 + c * 11) % 23) - 11, 1);

        // R2 R10: full-length runs on all lanes with varied samples
        half_mode = 1'b0;
        for (int s = 0; s < 34; s++) begin
            for (int c = 0; c < NL; c++) samp_v[c] = ((s * 37 + c * 19) % 255) - 127;
            send('1, 1);
            idle(33);
        end

        // R3: short mode
        half_mode = 1'b1;
        for (int s = 0; s < 6; s++) begin
            for (int c = 0; c < NL; c++) samp_v[c] = ((s * 53 + c * 7) % 200) - 100;
            send('1, 1);
            idle(18);
        end

        // R4 R5 timing for both modes
        timing(0, 1'b0);
        timing(2, 1'b1);

        // R3: half_mode change during a computation is not seen
        half_mode = 1'b0;
        samp_v[0] = 77;
        send(4'b0001, 1);
        idle(2);
        half_mode = 1'b1;
        idle(34);
        half_mode = 1'b0;

        // R6: write while lane 0 computes is ignored; tap 31 write ignored
        samp_v[0] = -90;
        send(4'b0001, 1);
        idle(2);
        wr_coef(0, 0, 99, 0);
        idle(34);
        wr_coef(0, 31, 55, 0);
        samp_v[0] = 64;
        send(4'b0001, 1);
        idle(34);

        // R8: lane 2 disabled ignores strobes, clk_en stays low
        lane_en = 4'b1011;
        for (int c = 0; c < NL; c++) samp_v[c] = 40 + c;
        send('1, 1);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 34; i++) begin
                @(negedge clk);
                if (clk_en[2]) seen++;
            end
            chk(seen == 0, "R8 clk_en of disabled lane", seen, 0);
        end
        lane_en = '1;
        samp_v[2] = -33;
        send(4'b0100, 1);
        idle(34);

        // R7: overrun on lane 1 only
        samp_v[1] = 21;
        send(4'b0010, 0);
        idle(4);
        chk(overrun[1] == 1'b0, "R7 overrun before second strobe", int'(overrun[1]), 0);
        samp_v[1] = -17;
        send(4'b0010, 1);
        chk(overrun[1] == 1'b1, "R7 overrun set", int'(overrun[1]), 1);
        chk(overrun[0] == 1'b0 && overrun[2] == 1'b0 && overrun[3] == 1'b0,
            "R10 overrun isolated", int'(overrun), 2);
        idle(34);
        chk(overrun[1] == 1'b1, "R7 overrun sticky", int'(overrun[1]), 1);

        // R9: full-scale on lane 3
        for (int k = 0; k < TAPS_FULL; k++) wr_coef(3, k, -128, 1);
        samp_v[3] = -128;
        for (int s = 0; s < TAPS_FULL; s++) begin
            send(4'b1000, 1);
            idle(33);
        end
        chk(int'($signed(y_out[3*ACC_W +: ACC_W])) == 491520, "R9 full-scale result",
            int'($signed(y_out[3*ACC_W +: ACC_W])), 491520);

        idle(5);
        chk(exp_q.size() == 0, "R2 R7 missing results", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule